// File: doc/BRIEF.md
# Protected watchdog timer

This block is a watchdog counter advanced by a slow 1 kHz tick strobe. Software must clear it before a programmed number of ticks has gone by. If it does not, the block raises a one-cycle reset request toward the system reset logic and starts counting again. The tick source, the fuse storage and the reset controller are outside the block.

One 8-bit control register holds the timer settings: a 4-bit period code, an enable bit and a change-enable bit. The register is protected. A write counts only if it lands within a short window opened by an unlock strobe, and only if the same write sets the change-enable bit.

An optional window mode adds a closed window before the open window. The length of the closed window comes from a separate input. A clear that arrives while the closed window is still running is treated as a fault.

Top module: `wdt_guard`

## Requirements
- R1: In reset the period code loads from `fuse_period` and the enable loads from `fuse_enable`. `rd_data` then reads `{2'b00, period[3:0], enable, 1'b0}`, and `reset_req` is low.
- R2: `rd_data[7:6]` and `rd_data[0]` always read 0. Bits 7:6 of a write have no effect.
- R3: An accepted write changes the period (`wr_data[5:2]`) and the enable (`wr_data[1]`) only when `wr_data[0]` is 1. Otherwise the register is unchanged.
- R4: A pulse on `unlock_stb` opens a window of 4 clock cycles. A write in any of the 4 cycles after the strobe is accepted. A write at any other time is ignored.
- R5: An accepted write whose period code is 11 to 15 leaves the period unchanged but still updates the enable.
- R6: With the block enabled and window mode off, `reset_req` is high for one cycle once 2^(code+3) ticks have been counted since the last clear or timeout. Codes 0 to 10 give 8 to 8192 ticks. The count restarts from zero after a timeout.
- R7: `wdt_clear` resets the count to zero. The count advances only on clock edges where `tick` is high.
- R8: While the block is disabled, `reset_req` stays low and clears have no effect.
- R9: In window mode the timeout comes after the sum of the closed-window ticks (`closed_code`, same encoding) and the open-window ticks (the period code).
- R10: In window mode, a clear while the count is below the closed-window length raises `reset_req` on the next cycle.
- R11: In window mode, a clear at or after the end of the closed window raises no request and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 1 kHz tick strobe, one clock cycle wide |
| fuse_period | input | 4 | Power-on period code |
| fuse_enable | input | 1 | Power-on enable |
| unlock_stb | input | 1 | Protection unlock strobe |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register read value |
| wdt_clear | input | 1 | Software clear strobe |
| win_mode | input | 1 | Selects window mode |
| closed_code | input | 4 | Closed-window length code |
| reset_req | output | 1 | One-cycle reset request |

## Verification
The bench probes both edges of the unlock window: a write in the fourth cycle after the strobe, and one in the fifth. An off-by-one in the window counter shows up as either a lost write or a write that should have been rejected.

It writes the reserved period codes and the reserved top bits. A design that decodes a reserved code would end up with a bogus period, and one that stores the top bits would read back nonzero bits 7:6.

It measures the number of ticks to timeout, first with a tick on every edge and then with a tick on every other edge. A design that counts clocks instead of ticks, or that is off by one at the limit, gives the wrong number.

In window mode it clears just inside and exactly at the closed boundary. A wrong comparison either misses the early-clear fault or fires on a legal clear.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam int unsigned CODE_W = 4;

  typedef struct packed {
    logic [1:0]        rsvd;
    logic [CODE_W-1:0] period;
    logic              enable;
    logic              chg_en;
  } wdt_ctrl_t;

  function automatic int unsigned code_to_ticks(input int unsigned code,
                                                input int unsigned base_log2,
                                                input int unsigned max_code);
    int unsigned c;
    c = (code > max_code) ? max_code : code;
    return 32'd1 << (base_log2 + c);
  endfunction
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock #(
  parameter int unsigned CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic unlock_stb,
  output logic open_win
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (unlock_stb) begin
      left_q <= CW'(CYCLES);
    end else if (left_q != '0) begin
      left_q <= left_q - CW'(1);
    end
  end

  assign open_win = (left_q != '0);
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_guard_pkg::*;
#(
  parameter int unsigned MAX_CODE = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] fuse_period,
  input  logic              fuse_enable,
  input  logic              wr_ok,
  input  logic [7:0]        wr_data,
  output logic [CODE_W-1:0] period_q,
  output logic              enable_q
);
  wdt_ctrl_t wr_f;
  logic      code_legal;

  assign wr_f       = wdt_ctrl_t'(wr_data);
  assign code_legal = (32'(wr_f.period) <= MAX_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= fuse_period;
      enable_q <= fuse_enable;
    end else if (wr_ok && wr_f.chg_en) begin
      enable_q <= wr_f.enable;
      if (code_legal) begin
        period_q <= wr_f.period;
      end
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             tick,
  input  logic             clear,
  input  logic             win_mode,
  input  logic [CNT_W-1:0] total_lim,
  input  logic [CNT_W-1:0] closed_lim,
  output logic [CNT_W-1:0] cnt_q,
  output logic             req_q
);
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (!enable) begin
        cnt_q <= '0;
      end else if (clear) begin
        cnt_q <= '0;
        if (win_mode && (cnt_q < closed_lim)) begin
          req_q <= 1'b1;
        end
      end else if (tick) begin
        if (cnt_inc >= total_lim) begin
          cnt_q <= '0;
          req_q <= 1'b1;
        end else begin
          cnt_q <= cnt_inc;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int unsigned UNLOCK_CYCLES = 4,
  parameter int unsigned MAX_CODE      = 10,
  parameter int unsigned BASE_LOG2     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CODE_W-1:0] fuse_period,
  input  logic              fuse_enable,
  input  logic              unlock_stb,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              wdt_clear,
  input  logic              win_mode,
  input  logic [CODE_W-1:0] closed_code,
  output logic              reset_req
);
  localparam int unsigned CNT_W = BASE_LOG2 + MAX_CODE + 2;

  logic              open_win;
  logic [CODE_W-1:0] period_q;
  logic              enable_q;
  logic [CNT_W-1:0]  open_lim;
  logic [CNT_W-1:0]  closed_lim;
  logic [CNT_W-1:0]  total_lim;
  logic [CNT_W-1:0]  tick_cnt;
  wdt_ctrl_t         rd_f;

  wdt_unlock #(.CYCLES(UNLOCK_CYCLES)) unlock_i (
    .clk(clk), .rst(rst), .unlock_stb(unlock_stb), .open_win(open_win)
  );

  wdt_ctrl #(.MAX_CODE(MAX_CODE)) ctrl_i (
    .clk(clk), .rst(rst), .fuse_period(fuse_period), .fuse_enable(fuse_enable),
    .wr_ok(open_win && wr_en), .wr_data(wr_data),
    .period_q(period_q), .enable_q(enable_q)
  );

  assign open_lim   = CNT_W'(code_to_ticks(32'(period_q), BASE_LOG2, MAX_CODE));
  assign closed_lim = CNT_W'(code_to_ticks(32'(closed_code), BASE_LOG2, MAX_CODE));
  assign total_lim  = win_mode ? (open_lim + closed_lim) : open_lim;

  wdt_counter #(.CNT_W(CNT_W)) counter_i (
    .clk(clk), .rst(rst), .enable(enable_q), .tick(tick), .clear(wdt_clear),
    .win_mode(win_mode), .total_lim(total_lim), .closed_lim(closed_lim),
    .cnt_q(tick_cnt), .req_q(reset_req)
  );

  always_comb begin
    rd_f        = '0;
    rd_f.period = period_q;
    rd_f.enable = enable_q;
  end
  assign rd_data = rd_f;
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int unsigned CNT_W = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic             wdt_clear,
  input logic             win_mode,
  input logic [7:0]       rd_data,
  input logic             reset_req,
  input logic [CNT_W-1:0] tick_cnt,
  input logic [CNT_W-1:0] closed_lim
);
  p_ce_required_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[0]) |=> $stable(rd_data));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rd_data));

  p_rsvd_code_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_data[5:2] > 4'd10)) |=> $stable(rd_data[5:2]));

  p_restart_r6: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> (tick_cnt == '0));

  p_no_req_disabled_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_data[1] |=> !reset_req);

  p_early_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_data[1] && win_mode && wdt_clear && (tick_cnt < closed_lim)) |=> reset_req);
endmodule

bind wdt_guard wdt_guard_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wdt_clear(wdt_clear),
  .win_mode(win_mode), .rd_data(rd_data), .reset_req(reset_req),
  .tick_cnt(tick_cnt), .closed_lim(closed_lim)
);

// File: tb/wdt_guard_tb_top.sv
module wdt_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {unlock, idle[2:0], wr_data, expected rd_data}
  localparam logic [19:0] VEC [0:NVEC-1] = '{
    {1'b1, 3'd0, 8'h07, 8'h06},  // R3 accepted: code1 en1
    {1'b1, 3'd0, 8'h14, 8'h06},  // R3 change-enable clear: ignored
    {1'b0, 3'd0, 8'h15, 8'h06},  // R4 no unlock: ignored
    {1'b1, 3'd3, 8'h15, 8'h14},  // R4 last open cycle: code5 en0
    {1'b1, 3'd4, 8'h0B, 8'h14},  // R4 one cycle late: ignored
    {1'b1, 3'd0, 8'h2F, 8'h16},  // R5 code 11 kept at 5, en1
    {1'b1, 3'd0, 8'hE9, 8'h28},  // R2 top bits dropped: code10 en0
    {1'b1, 3'd0, 8'h3F, 8'h2A},  // R5 code 15 kept at 10, en1
    {1'b1, 3'd1, 8'h01, 8'h00}   // R4 second cycle: code0 en0
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic [3:0] fuse_period = 4'd2;
  logic       fuse_enable = 1'b0;
  logic       unlock_stb = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       wdt_clear = 1'b0;
  logic       win_mode = 1'b0;
  logic [3:0] closed_code = 4'd0;
  logic       reset_req;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_guard dut_i (
    .clk(clk), .rst(rst), .tick(tick), .fuse_period(fuse_period),
    .fuse_enable(fuse_enable), .unlock_stb(unlock_stb), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .wdt_clear(wdt_clear),
    .win_mode(win_mode), .closed_code(closed_code), .reset_req(reset_req)
  );

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] fp, input logic fe);
    @(negedge clk);
    rst = 1'b1;
    fuse_period = fp;
    fuse_enable = fe;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_write(input bit unl, input int idle, input logic [7:0] d);
    if (unl) begin
      unlock_stb = 1'b1;
      @(negedge clk);
      unlock_stb = 1'b0;
    end
    repeat (idle) @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  // counts ticks until reset_req; optional clear first; half selects a tick on every other edge
  task automatic measure(input bit do_clr, input bit half, output int nt);
    nt = 0;
    if (do_clr) begin
      wdt_clear = 1'b1;
      @(negedge clk);
      wdt_clear = 1'b0;
    end
    for (int i = 0; i < 40000; i++) begin
      tick = half ? i[0] : 1'b1;
      @(posedge clk);
      if (tick) nt++;
      @(negedge clk);
      if (reset_req) break;
    end
    tick = 1'b1;
  endtask

  task automatic clear_after(input int k, output logic req);
    wdt_clear = 1'b1;
    @(negedge clk);
    wdt_clear = 1'b0;
    repeat (k) @(negedge clk);
    wdt_clear = 1'b1;
    @(negedge clk);
    wdt_clear = 1'b0;
    req = reset_req;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int nt;
    int reqs;
    logic rq;

    // R1 reset state
    do_reset(4'd2, 1'b0);
    @(negedge clk);
    check("R1 rd_data after reset", rd_data, 8'h08);
    check("R1 reset_req after reset", reset_req, 0);

    // register table: R2 R3 R4 R5
    for (int v = 0; v < NVEC; v++) begin
      repeat (5) @(negedge clk);
      do_write(VEC[v][19], int'(VEC[v][18:16]), VEC[v][15:8]);
      check($sformatf("table R2 R3 R4 R5 vec %0d", v), rd_data, VEC[v][7:0]);
    end

    // R1 fuse load, enabled
    do_reset(4'd0, 1'b1);
    @(negedge clk);
    check("R1 rd_data enabled fuse", rd_data, 8'h02);

    // R6 timeout and restart
    measure(1'b1, 1'b0, nt);
    check("R6 ticks to timeout code0", nt, 8);
    measure(1'b0, 1'b0, nt);
    check("R6 ticks after restart", nt, 8);
    @(negedge clk);
    check("R6 request lasts one cycle", reset_req, 0);

    // R7 clear midway and tick gating
    wdt_clear = 1'b1;
    @(negedge clk);
    wdt_clear = 1'b0;
    reqs = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (reset_req) reqs++;
    end
    check("R7 no request before limit", reqs, 0);
    measure(1'b1, 1'b1, nt);
    check("R7 ticks counted with sparse tick", nt, 8);

    // R6 longer period
    do_write(1'b1, 0, 8'h0F);
    measure(1'b1, 1'b0, nt);
    check("R6 ticks to timeout code3", nt, 64);

    // R8 disabled
    do_write(1'b1, 0, 8'h01);
    check("R8 rd_data disabled", rd_data, 8'h00);
    reqs = 0;
    for (int i = 0; i < 40; i++) begin
      wdt_clear = (i % 10) == 0;
      @(negedge clk);
      if (reset_req) reqs++;
    end
    wdt_clear = 1'b0;
    check("R8 no request while disabled", reqs, 0);

    // R9 window mode totals
    win_mode = 1'b1;
    closed_code = 4'd0;
    do_write(1'b1, 0, 8'h03);
    measure(1'b1, 1'b0, nt);
    check("R9 window total 8+8", nt, 16);
    closed_code = 4'd2;
    do_write(1'b1, 0, 8'h07);
    measure(1'b1, 1'b0, nt);
    check("R9 window total 32+16", nt, 48);

    // R10 early clear, R11 clear at boundary
    closed_code = 4'd0;
    do_write(1'b1, 0, 8'h03);
    clear_after(3, rq);
    check("R10 clear inside closed window", rq, 1);
    repeat (2) @(negedge clk);
    clear_after(8, rq);
    check("R11 clear at closed boundary", rq, 0);
    measure(1'b0, 1'b0, nt);
    check("R11 count restarted by legal clear", nt, 16);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule